// File: doc/BRIEF.md
# Two-Bank Endpoint Ownership Tracker

This block keeps track of who owns each data bank of a device-side USB endpoint that has two banks. The local processor works on one bank while the bus engine works on the other. The block holds a ring made of a head pointer and a count of banks committed to the bus. It also keeps the byte count of the bank the processor is using and the stored length of each committed bank. From this state it raises sticky event flags and one combined interrupt. Packet serialisation, CRC calculation and data RAM are handled elsewhere. Only the pointers and lengths are held here.

For a transmit (IN) endpoint, the processor fills a bank and hands it over by pulsing a release strobe. The bus engine reports each packet it has read out. An abort path discards the most recently committed bank that has not yet been sent. For a receive (OUT) endpoint, the bus engine deposits packets with a length and a CRC verdict, and the processor drains the banks. In isochronous operation the block reports two conditions: a read of an empty bank, and a packet lost because both banks were full. A bad CRC raises a stall-type flag, and the receive flag is still raised for that packet. A parameter reduces the block to a single bank.

Top module: `ep_dual_bank_mgr`

## Requirements
- R1: While `rst_n` is low, and after an edge with `ep_reset` high, the following all read 0: `busy_banks`, `flags`, `cpu_bank`, `cpu_byte_cnt`, `head_bank` and `kill_pending`.
- R2: Flag encoding is bit 0 transmit-ready, bit 1 receive-ready, bit 2 underflow, bit 3 CRC stall. With `cfg_dir_in`=1, bit 0 sets on the first edge after a reset ends. A release while a bank is free commits the processor bank, increments `busy_banks` and moves `cpu_bank` to the other bank. If a bank is still free after that, bit 0 sets on the same edge.
- R3: `busy_banks` never exceeds NUM_BANKS. A release while all banks are busy is ignored. When a bus read frees a bank from the full state, flag bit 0 sets.
- R4: With NUM_BANKS=1, flag bit 0 stays clear after a release and sets only when the bus read empties the bank.
- R5: On an IN endpoint, a bus read of a busy bank decrements `busy_banks` and advances `head_bank`. `head_len` then shows the length committed in the next bank.
- R6: `cpu_kill` sets `kill_pending` for exactly one cycle. On that cycle the last committed bank is dropped: `busy_banks` decrements, `cpu_bank` returns to that bank and `cpu_byte_cnt` clears. A kill with no busy bank changes nothing. A kill and a bus read on the same edge are both applied.
- R7: With `cfg_iso`=1 and `cfg_dir_in`=1, a bus read while `busy_banks`=0 sets flag bit 2. With `cfg_iso`=0 it does not.
- R8: On an OUT endpoint, a received packet with a free bank is stored in it: `busy_banks` increments, the length is kept and flag bit 1 sets. A packet that arrives with all banks full is dropped, leaving `busy_banks` and `head_len` unchanged, and sets flag bit 2 when `cfg_iso`=1. A release while another bank is still full sets flag bit 1 again.
- R9: With `cfg_iso`=1, a stored OUT packet with `bus_rx_crc_ok`=0 sets flag bit 3 and also flag bit 1.
- R10: On an OUT endpoint the processor reads only while `rw_allowed`=1, that is, while a bank is busy and unread bytes remain. A read strobe at other times leaves `cpu_byte_cnt` unchanged and raises no flag.
- R11: Each flag stays set until `flag_clr` writes 1 to its bit. If a set event and a clear occur on the same edge, the flag stays set. `irq` is the OR of `flags & irq_en`.
- R12: On an IN endpoint each byte strobe increments `cpu_byte_cnt`, up to MAX_PKT and no further. A release stores this count as the bank's length, and the count then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_reset | input | 1 | Synchronous endpoint reset |
| cfg_dir_in | input | 1 | 1 = transmit (IN) endpoint, 0 = receive (OUT); changed only with ep_reset |
| cfg_iso | input | 1 | Isochronous error reporting enable |
| cpu_byte_stb | input | 1 | Processor writes (IN) or reads (OUT) one byte |
| cpu_release | input | 1 | Processor hands its bank over |
| cpu_kill | input | 1 | Request to discard the last committed IN bank |
| flag_clr | input | 4 | Write-one-to-clear for the flags |
| irq_en | input | 4 | Per-flag interrupt enables |
| bus_in_done | input | 1 | Bus engine finished reading an IN packet |
| bus_rx_valid | input | 1 | Bus engine delivers an OUT packet |
| bus_rx_len | input | LEN_W | Byte length of the delivered packet |
| bus_rx_crc_ok | input | 1 | CRC verdict of the delivered packet |
| flags | output | 4 | Sticky flags |
| irq | output | 1 | Combined interrupt |
| busy_banks | output | 2 | Banks owned by the bus side (IN) or holding data (OUT) |
| cpu_bank | output | 1 | Bank the processor works on |
| cpu_byte_cnt | output | LEN_W | Bytes written or read in the processor bank |
| rw_allowed | output | 1 | Processor may move a byte |
| kill_pending | output | 1 | Kill request in progress |
| head_bank | output | 1 | Oldest busy bank |
| head_len | output | LEN_W | Stored length of the head bank |

## Verification
The bench checks that flag bit 0 sets on the same edge as a release when a second bank is free. A design that waited for the bus to drain would leave it clear, and in single-bank mode the bench checks the opposite. It kills both committed banks one after the other and then once with nothing busy. A design that took the wrong bank would show a stale length on the head. It also puts a kill and a bus read on the same edge, where a design that applied only one of them would report one bank still busy. On the receive side it fills both banks and then sends a third packet, overdrives the read strobe past the stored length, and strobes with no bank busy. These catch a design that overwrites a held bank or that counts beyond the stored data. Clear-versus-set collisions and a CRC failure that must still raise the receive flag are also covered.

// File: rtl/ep_bank_pkg.sv
package ep_bank_pkg;

   localparam int FLG_W   = 4;
   localparam int FLG_TX  = 0;
   localparam int FLG_RX  = 1;
   localparam int FLG_UND = 2;
   localparam int FLG_CRC = 3;

   typedef logic [FLG_W-1:0] flag_vec_t;

endpackage

// File: rtl/ep_flag_bank.sv
module ep_flag_bank
   import ep_bank_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ep_reset,
   input  flag_vec_t set_evt,
   input  flag_vec_t clr,
   input  flag_vec_t en,
   output flag_vec_t flags,
   output logic      irq
);

   flag_vec_t flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flags_q <= '0;
      else if (ep_reset) flags_q <= '0;
      else               flags_q <= (flags_q & ~clr) | set_evt;
   end

   assign flags = flags_q;
   assign irq   = |(flags_q & en);

   for (genvar i = 0; i < FLG_W; i++) begin : g_chk
      // R11: a flag holds until its clear bit is written
      p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (flags_q[i] && !clr[i] && !ep_reset) |=> flags_q[i]);
      // R11: a clear without a simultaneous set drops the flag
      p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !set_evt[i] && !ep_reset) |=> !flags_q[i]);
   end

endmodule

// File: rtl/ep_bank_queue.sv
module ep_bank_queue
   import ep_bank_pkg::*;
#(
   parameter int NUM_BANKS = 2,
   parameter int MAX_PKT   = 64,
   parameter int LEN_W     = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ep_reset,
   input  logic             dir_in,
   input  logic             iso,
   input  logic             byte_stb,
   input  logic             release_req,
   input  logic             kill_req,
   input  logic             bus_done,
   input  logic             bus_rx,
   input  logic [LEN_W-1:0] bus_rx_len,
   input  logic             bus_crc_ok,
   output logic [1:0]       busy,
   output logic             cpu_ptr,
   output logic             head_ptr,
   output logic [LEN_W-1:0] cpu_cnt,
   output logic [LEN_W-1:0] head_len,
   output logic             rwal,
   output logic             kill_pend,
   output flag_vec_t        events
);

   localparam logic [1:0]       NB   = 2'(NUM_BANKS);
   localparam logic [LEN_W-1:0] MAXL = LEN_W'(MAX_PKT);

   logic [1:0]       n_q, n1, n_next;
   logic             hd_q, hd_inc, tail_ptr;
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] len_q [NUM_BANKS];
   logic             kill_q, armed_q;
   logic             done_eff, kill_eff, rel_in, rel_out, land, drop, adv;
   logic             avail_now, avail_next;

   // pointer arithmetic depends on the bank count
   if (NUM_BANKS == 2) begin : g_two
      assign tail_ptr = hd_q ^ n_q[0];
      assign hd_inc   = ~hd_q;
   end else begin : g_one
      assign tail_ptr = 1'b0;
      assign hd_inc   = 1'b0;
   end

   always_comb begin
      head_len = '0;
      for (int b = 0; b < NUM_BANKS; b++)
         if (hd_q == 1'(b)) head_len = len_q[b];
   end

   // transmit side
   assign done_eff = dir_in & bus_done & (n_q != 2'd0);
   assign n1       = n_q - {1'b0, done_eff};
   assign kill_eff = dir_in & kill_q & (n1 != 2'd0);
   assign rel_in   = dir_in & release_req & ~kill_q & (n_q < NB);
   // receive side
   assign land     = ~dir_in & bus_rx & (n_q < NB);
   assign drop     = ~dir_in & bus_rx & (n_q == NB);
   assign rel_out  = ~dir_in & release_req & (n_q != 2'd0);

   assign n_next = n1 - {1'b0, kill_eff} + {1'b0, rel_in}
                 + {1'b0, land} - {1'b0, rel_out};
   assign adv    = done_eff | rel_out;

   assign rwal = dir_in ? ((n_q < NB) && (cnt_q < MAXL))
                        : ((n_q != 2'd0) && (cnt_q < head_len));

   assign avail_now  = (n_q < NB);
   assign avail_next = (n_next < NB);

   always_comb begin
      events          = '0;
      events[FLG_TX]  = dir_in & (~armed_q | (avail_next & (~avail_now | rel_in)));
      events[FLG_RX]  = land | (rel_out & (n_next != 2'd0));
      events[FLG_UND] = iso & ((dir_in & bus_done & (n_q == 2'd0)) | drop);
      events[FLG_CRC] = iso & land & ~bus_crc_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_q     <= '0;
         hd_q    <= 1'b0;
         cnt_q   <= '0;
         kill_q  <= 1'b0;
         armed_q <= 1'b0;
         for (int b = 0; b < NUM_BANKS; b++) len_q[b] <= '0;
      end else if (ep_reset) begin
         n_q     <= '0;
         hd_q    <= 1'b0;
         cnt_q   <= '0;
         kill_q  <= 1'b0;
         armed_q <= 1'b0;
         for (int b = 0; b < NUM_BANKS; b++) len_q[b] <= '0;
      end else begin
         n_q     <= n_next;
         armed_q <= 1'b1;
         kill_q  <= kill_req & dir_in;
         if (adv) hd_q <= hd_inc;
         if (rel_in | kill_eff | rel_out) cnt_q <= '0;
         else if (byte_stb & rwal)        cnt_q <= cnt_q + 1'b1;
         for (int b = 0; b < NUM_BANKS; b++) begin
            if (tail_ptr == 1'(b)) begin
               if (rel_in)    len_q[b] <= cnt_q;
               else if (land) len_q[b] <= bus_rx_len;
            end
         end
      end
   end

   assign busy      = n_q;
   assign head_ptr  = hd_q;
   assign cpu_ptr   = dir_in ? tail_ptr : hd_q;
   assign cpu_cnt   = cnt_q;
   assign kill_pend = kill_q;

   // R3: never more committed banks than exist
   p_busy_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      n_q <= NB);
   // R3: release with every bank busy changes nothing
   p_full_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_in && release_req && n_q == NB && !bus_done && !kill_q && !ep_reset)
      |=> n_q == NB);
   // R6: a pending kill with a busy bank drops exactly one
   p_kill_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_in && kill_q && n_q != 2'd0 && !bus_done && !ep_reset)
      |=> n_q == $past(n_q) - 2'd1);
   // R1: endpoint reset empties the ring
   p_ep_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ep_reset |=> (n_q == 2'd0 && cnt_q == '0 && !kill_q));
   // R8: a packet arriving into full banks is dropped
   p_out_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_in && bus_rx && n_q == NB && !release_req && !ep_reset)
      |=> (n_q == NB && $stable(head_len)));
   // R10: a processor read without permission has no effect
   p_no_cpu_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_in && byte_stb && !rwal && !release_req && !ep_reset)
      |=> $stable(cnt_q));

endmodule

// File: rtl/ep_dual_bank_mgr.sv
module ep_dual_bank_mgr
   import ep_bank_pkg::*;
#(
   parameter int NUM_BANKS = 2,
   parameter int MAX_PKT   = 64,
   parameter int LEN_W     = $clog2(MAX_PKT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ep_reset,
   input  logic             cfg_dir_in,
   input  logic             cfg_iso,
   input  logic             cpu_byte_stb,
   input  logic             cpu_release,
   input  logic             cpu_kill,
   input  logic [3:0]       flag_clr,
   input  logic [3:0]       irq_en,
   input  logic             bus_in_done,
   input  logic             bus_rx_valid,
   input  logic [LEN_W-1:0] bus_rx_len,
   input  logic             bus_rx_crc_ok,
   output logic [3:0]       flags,
   output logic             irq,
   output logic [1:0]       busy_banks,
   output logic             cpu_bank,
   output logic [LEN_W-1:0] cpu_byte_cnt,
   output logic             rw_allowed,
   output logic             kill_pending,
   output logic             head_bank,
   output logic [LEN_W-1:0] head_len
);

   localparam logic [1:0] NB = 2'(NUM_BANKS);

   if (NUM_BANKS < 1 || NUM_BANKS > 2) begin : g_bad_banks
      $error("NUM_BANKS must be 1 or 2");
   end
   if (LEN_W < $clog2(MAX_PKT + 1)) begin : g_bad_len
      $error("LEN_W too narrow for MAX_PKT");
   end
   if (MAX_PKT < 1) begin : g_bad_pkt
      $error("MAX_PKT must be positive");
   end

   flag_vec_t evt;

   ep_bank_queue #(
      .NUM_BANKS (NUM_BANKS),
      .MAX_PKT   (MAX_PKT),
      .LEN_W     (LEN_W)
   ) u_queue (
      .clk         (clk),
      .rst_n       (rst_n),
      .ep_reset    (ep_reset),
      .dir_in      (cfg_dir_in),
      .iso         (cfg_iso),
      .byte_stb    (cpu_byte_stb),
      .release_req (cpu_release),
      .kill_req    (cpu_kill),
      .bus_done    (bus_in_done),
      .bus_rx      (bus_rx_valid),
      .bus_rx_len  (bus_rx_len),
      .bus_crc_ok  (bus_rx_crc_ok),
      .busy        (busy_banks),
      .cpu_ptr     (cpu_bank),
      .head_ptr    (head_bank),
      .cpu_cnt     (cpu_byte_cnt),
      .head_len    (head_len),
      .rwal        (rw_allowed),
      .kill_pend   (kill_pending),
      .events      (evt)
   );

   ep_flag_bank u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .ep_reset (ep_reset),
      .set_evt  (evt),
      .clr      (flag_clr),
      .en       (irq_en),
      .flags    (flags),
      .irq      (irq)
   );

   // R7: isochronous read of an empty IN bank flags underflow
   p_in_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_dir_in && cfg_iso && bus_in_done && busy_banks == 2'd0 && !ep_reset)
      |=> flags[FLG_UND]);
   // R9: a CRC failure still raises the receive flag
   p_crc_keeps_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_dir_in && cfg_iso && bus_rx_valid && busy_banks < NB
       && !bus_rx_crc_ok && !ep_reset)
      |=> (flags[FLG_CRC] && flags[FLG_RX]));
   // R2: a release leaving a bank free re-arms transmit-ready at once
   p_tx_rearm_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_dir_in && cpu_release && !kill_pending && !ep_reset
       && busy_banks + 2'd1 < NB) |=> flags[FLG_TX]);

endmodule

// File: tb/ep_dual_bank_mgr_tb.sv
module ep_dual_bank_mgr_tb;

   localparam int CLK_PERIOD = 10;
   localparam int LEN_W      = 7;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ep_reset = 1'b0;
   logic             cfg_dir_in = 1'b1;
   logic             cfg_iso = 1'b0;
   logic             cpu_byte_stb = 1'b0;
   logic             cpu_release = 1'b0;
   logic             cpu_kill = 1'b0;
   logic [3:0]       flag_clr = 4'd0;
   logic [3:0]       irq_en = 4'd0;
   logic             bus_in_done = 1'b0;
   logic             bus_rx_valid = 1'b0;
   logic [LEN_W-1:0] bus_rx_len = '0;
   logic             bus_rx_crc_ok = 1'b1;

   logic [3:0]       flags, sb_flags;
   logic             irq, sb_irq;
   logic [1:0]       busy, sb_busy;
   logic             cpu_bank, sb_cpu_bank;
   logic [LEN_W-1:0] byte_cnt, sb_byte_cnt;
   logic             rwal, sb_rwal;
   logic             kill_pend, sb_kill_pend;
   logic             head_bank, sb_head_bank;
   logic [LEN_W-1:0] head_len, sb_head_len;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ep_dual_bank_mgr #(.NUM_BANKS(2), .MAX_PKT(64)) u_dut (
      .clk(clk), .rst_n(rst_n), .ep_reset(ep_reset), .cfg_dir_in(cfg_dir_in),
      .cfg_iso(cfg_iso), .cpu_byte_stb(cpu_byte_stb), .cpu_release(cpu_release),
      .cpu_kill(cpu_kill), .flag_clr(flag_clr), .irq_en(irq_en),
      .bus_in_done(bus_in_done), .bus_rx_valid(bus_rx_valid),
      .bus_rx_len(bus_rx_len), .bus_rx_crc_ok(bus_rx_crc_ok),
      .flags(flags), .irq(irq), .busy_banks(busy), .cpu_bank(cpu_bank),
      .cpu_byte_cnt(byte_cnt), .rw_allowed(rwal), .kill_pending(kill_pend),
      .head_bank(head_bank), .head_len(head_len));

   ep_dual_bank_mgr #(.NUM_BANKS(1), .MAX_PKT(64)) u_dut_sb (
      .clk(clk), .rst_n(rst_n), .ep_reset(ep_reset), .cfg_dir_in(cfg_dir_in),
      .cfg_iso(cfg_iso), .cpu_byte_stb(cpu_byte_stb), .cpu_release(cpu_release),
      .cpu_kill(cpu_kill), .flag_clr(flag_clr), .irq_en(irq_en),
      .bus_in_done(bus_in_done), .bus_rx_valid(bus_rx_valid),
      .bus_rx_len(bus_rx_len), .bus_rx_crc_ok(bus_rx_crc_ok),
      .flags(sb_flags), .irq(sb_irq), .busy_banks(sb_busy),
      .cpu_bank(sb_cpu_bank), .cpu_byte_cnt(sb_byte_cnt), .rw_allowed(sb_rwal),
      .kill_pending(sb_kill_pend), .head_bank(sb_head_bank),
      .head_len(sb_head_len));

   task automatic check(input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic release_bank();
      cpu_release = 1'b1; step(); cpu_release = 1'b0;
   endtask

   task automatic write_bytes(input int k);
      for (int i = 0; i < k; i++) begin
         cpu_byte_stb = 1'b1; step();
      end
      cpu_byte_stb = 1'b0;
   endtask

   task automatic bus_read();
      bus_in_done = 1'b1; step(); bus_in_done = 1'b0;
   endtask

   task automatic rx_packet(input int len, input bit ok);
      bus_rx_valid = 1'b1; bus_rx_len = LEN_W'(len); bus_rx_crc_ok = ok;
      step();
      bus_rx_valid = 1'b0; bus_rx_crc_ok = 1'b1;
   endtask

   task automatic clear_flags(input logic [3:0] m);
      flag_clr = m; step(); flag_clr = 4'd0;
   endtask

   task automatic pulse_ep_reset();
      ep_reset = 1'b1; step(); ep_reset = 1'b0;
   endtask

   task automatic t_reset();
      step(); step();
      check("R1", "busy in reset", busy, 0);
      check("R1", "flags in reset", flags, 0);
      check("R1", "cpu_bank in reset", cpu_bank, 0);
      check("R1", "byte count in reset", byte_cnt, 0);
      check("R1", "kill_pending in reset", kill_pend, 0);
      rst_n = 1'b1;
      step();
      check("R2", "tx ready after reset", flags[0], 1);
   endtask

   task automatic t_in_double();
      clear_flags(4'hF);
      check("R11", "flags cleared", flags, 0);
      write_bytes(5);
      check("R12", "bytes written", byte_cnt, 5);
      release_bank();
      check("R2", "busy after first release", busy, 1);
      check("R2", "cpu bank switched", cpu_bank, 1);
      check("R2", "tx ready re-armed", flags[0], 1);
      check("R12", "count reset on release", byte_cnt, 0);
      check("R12", "committed length", head_len, 5);
      clear_flags(4'h1);
      write_bytes(3);
      release_bank();
      check("R3", "busy full", busy, 2);
      check("R3", "tx ready stays clear when full", flags[0], 0);
      check("R3", "no write when full", rwal, 0);
      release_bank();
      check("R3", "release ignored when full", busy, 2);
      bus_read();
      check("R5", "busy after read", busy, 1);
      check("R5", "head advanced", head_bank, 1);
      check("R5", "head length of second bank", head_len, 3);
      check("R3", "tx ready after bank freed", flags[0], 1);
      bus_read();
      check("R5", "busy drained", busy, 0);
   endtask

   task automatic t_kill();
      write_bytes(4); release_bank();
      write_bytes(2); release_bank();
      check("R6", "busy before kill", busy, 2);
      cpu_kill = 1'b1; step(); cpu_kill = 1'b0;
      check("R6", "kill pending set", kill_pend, 1);
      check("R6", "busy while pending", busy, 2);
      step();
      check("R6", "kill pending cleared", kill_pend, 0);
      check("R6", "busy after kill", busy, 1);
      check("R6", "cpu bank back on killed bank", cpu_bank, 1);
      check("R6", "byte count cleared", byte_cnt, 0);
      check("R6", "head keeps older bank", head_len, 4);
      cpu_kill = 1'b1; step(); cpu_kill = 1'b0; step();
      check("R6", "second kill empties", busy, 0);
      check("R6", "cpu bank after second kill", cpu_bank, 0);
      cpu_kill = 1'b1; step(); cpu_kill = 1'b0; step();
      check("R6", "kill with nothing busy", busy, 0);
      check("R6", "cpu bank unchanged", cpu_bank, 0);
      write_bytes(1); release_bank();
      write_bytes(1); release_bank();
      cpu_kill = 1'b1; step(); cpu_kill = 1'b0;
      bus_in_done = 1'b1; step(); bus_in_done = 1'b0;
      check("R6", "kill and read same edge", busy, 0);
      check("R6", "cpu bank after kill+read", cpu_bank, 1);
   endtask

   task automatic t_in_underflow();
      cfg_iso = 1'b1;
      clear_flags(4'hF);
      bus_read();
      check("R7", "iso empty read flags", flags, 4'b0100);
      check("R7", "busy stays empty", busy, 0);
      irq_en = 4'b1011; step();
      check("R11", "masked irq", irq, 0);
      irq_en = 4'b0100; step();
      check("R11", "enabled irq", irq, 1);
      flag_clr = 4'b0100; bus_in_done = 1'b1; step();
      flag_clr = 4'd0; bus_in_done = 1'b0;
      check("R11", "set wins over clear", flags[2], 1);
      step();
      check("R11", "flag sticky", flags[2], 1);
      clear_flags(4'b0100);
      check("R11", "flag cleared", flags[2], 0);
      check("R11", "irq drops", irq, 0);
      cfg_iso = 1'b0;
      bus_read();
      check("R7", "non-iso empty read silent", flags[2], 0);
      irq_en = 4'd0;
   endtask

   task automatic t_out();
      cfg_dir_in = 1'b0;
      pulse_ep_reset();
      check("R1", "busy after ep_reset", busy, 0);
      check("R1", "flags after ep_reset", flags, 0);
      check("R1", "cpu bank after ep_reset", cpu_bank, 0);
      check("R1", "head bank after ep_reset", head_bank, 0);
      cfg_iso = 1'b1;
      rx_packet(10, 1'b1);
      check("R8", "busy after rx", busy, 1);
      check("R8", "rx flag", flags, 4'b0010);
      check("R8", "stored length", head_len, 10);
      check("R10", "read allowed", rwal, 1);
      rx_packet(7, 1'b0);
      check("R8", "busy full", busy, 2);
      check("R9", "crc stall flag", flags[3], 1);
      check("R9", "rx flag with bad crc", flags[1], 1);
      clear_flags(4'hF);
      rx_packet(5, 1'b1);
      check("R8", "dropped packet busy", busy, 2);
      check("R8", "overflow flags", flags, 4'b0100);
      check("R8", "head length kept", head_len, 10);
      clear_flags(4'hF);
      write_bytes(11);
      check("R10", "read stops at length", byte_cnt, 10);
      check("R10", "read not allowed past end", rwal, 0);
      check("R10", "no flag from over-read", flags, 0);
      release_bank();
      check("R8", "busy after release", busy, 1);
      check("R8", "head advanced", head_bank, 1);
      check("R8", "next length", head_len, 7);
      check("R8", "rx flag again", flags, 4'b0010);
      release_bank();
      check("R8", "busy drained", busy, 0);
      clear_flags(4'hF);
      write_bytes(1);
      check("R10", "strobe with empty banks", byte_cnt, 0);
      check("R10", "no underflow from cpu", flags, 0);
   endtask

   task automatic t_single();
      cfg_dir_in = 1'b1; cfg_iso = 1'b0;
      pulse_ep_reset();
      step();
      check("R4", "single bank tx ready after reset", sb_flags[0], 1);
      clear_flags(4'hF);
      write_bytes(2);
      release_bank();
      check("R4", "single bank busy", sb_busy, 1);
      check("R4", "no re-arm with single bank", sb_flags[0], 0);
      check("R4", "no write while busy", sb_rwal, 0);
      bus_read();
      check("R4", "single bank drained", sb_busy, 0);
      check("R4", "re-arm after drain", sb_flags[0], 1);
   endtask

   task automatic t_cap();
      write_bytes(70);
      check("R12", "count saturates", byte_cnt, 64);
      release_bank();
      check("R12", "saturated length committed", head_len, 64);
   endtask

   initial begin
      t_reset();
      t_in_double();
      t_kill();
      t_in_underflow();
      t_out();
      t_single();
      t_cap();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule